// File: doc/BRIEF.md
# Packed signed quadword greater-than unit

This execution unit takes two 256-bit operands, splits each into four 64-bit two's-complement elements, and tests in every lane whether the element of the first operand is strictly larger than the matching element of the second. Each lane of the result is then filled with a full-width mask: all ones when the test holds, all zeros when it does not. The unit touches no status or condition flags.

A 2-bit mode input sets how much of the 256-bit destination is produced. Two narrow modes compute only the lower two lanes. One of them carries the upper 128 bits over from the prior destination value. The other clears those upper bits. A wide mode computes all four lanes as two independent 128-bit halves. The fourth code is illegal. It raises an undefined-operation flag and leaves the whole destination as it was. Every operation is accepted with an input strobe, and its result, strobe and flag appear from registers one clock later.

Top module: `sqcmp_unit`

## Requirements
- R1: Each 64-bit lane compares its two elements as signed two's-complement values with a strict greater-than. Equal elements give false. The most negative value compared against the most positive gives false. The most positive value compared against -1 gives true.
- R2: A computed lane is written as 64 ones when its compare is true and as 64 zeros when it is false.
- R3: Mode 2'b10 (wide) computes all four lanes. Each lane depends only on its own pair of elements.
- R4: Mode 2'b00 (narrow, keep) computes lanes 0 and 1 (bits 127:0). Bits 255:128 of the result equal bits 255:128 of the prior destination input.
- R5: Mode 2'b01 (narrow, clear) computes lanes 0 and 1. Bits 255:128 of the result are zero.
- R6: `out_illegal` is 1 for an operation with mode 2'b11 and 0 for an operation with any other mode.
- R7: For mode 2'b11 all 256 result bits equal the prior destination input.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_result` and `out_illegal` for that operation are presented in the same cycle. Back-to-back operations are accepted on consecutive cycles.
- R9: While `in_valid` is low, `out_valid` is low and `out_result` and `out_illegal` hold their values, whatever the other inputs do.
- R10: A synchronous active-high reset clears `out_result`, `out_valid` and `out_illegal` to zero.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | 00 narrow keep, 01 narrow clear, 10 wide, 11 illegal |
| src_a | input | 256 | First operand, four signed 64-bit elements |
| src_b | input | 256 | Second operand, four signed 64-bit elements |
| dest_prev | input | 256 | Prior destination value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 256 | Registered per-lane mask result |
| out_illegal | output | 1 | Undefined-operation flag for the presented result |

## Verification
The only state is the result register with its strobe and flag, so any fault in lane selection or upper-half handling shows up in the very next cycle's `out_result` as a lane that is not a clean mask or an upper half that is neither carried nor cleared. A stale or wrongly loaded register shows as a change of `out_result` during idle cycles, or as a result that does not match the operation presented one cycle earlier. The sign-boundary pairs (equal values, extreme values, -1) separate a signed compare from an unsigned one or a greater-or-equal compare in the first result they touch.

// File: rtl/sqcmp_pkg.sv
package sqcmp_pkg;

    localparam int ELEM_W    = 64;
    localparam int ELEM_CNT  = 4;

    typedef enum logic [1:0] {
        MODE_KEEP128 = 2'b00,
        MODE_ZERO128 = 2'b01,
        MODE_FULL256 = 2'b10,
        MODE_BAD     = 2'b11
    } mode_e;

    // state carried alongside the result register
    typedef struct packed {
        logic vld;
        logic illegal;
    } stat_t;

    function automatic logic mode_is_narrow(input mode_e m);
        return (m == MODE_KEEP128) || (m == MODE_ZERO128);
    endfunction

endpackage

// File: rtl/sqcmp_decode.sv
module sqcmp_decode
    import sqcmp_pkg::*;
#(
    parameter int LANES = ELEM_CNT
) (
    input  logic [1:0]       mode,
    output logic             illegal,
    output logic [LANES-1:0] compute,
    output logic [LANES-1:0] clear
);
    localparam int HALF = LANES / 2;

    mode_e m;
    logic [LANES-1:0] lower_mask;

    assign m = mode_e'(mode);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_low
            if (i < HALF) begin : g_in
                assign lower_mask[i] = 1'b1;
            end else begin : g_out
                assign lower_mask[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        illegal = 1'b0;
        compute = '0;
        clear   = '0;
        if (mode_is_narrow(m)) begin
            compute = lower_mask;
            if (m == MODE_ZERO128) clear = ~lower_mask;
        end else if (m == MODE_FULL256) begin
            compute = '1;
        end else begin
            illegal = 1'b1;
        end
    end
endmodule

// File: rtl/sqcmp_lane.sv
module sqcmp_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         compute,
    input  logic         clear,
    input  logic [W-1:0] prior,
    output logic [W-1:0] lane_out
);
    logic gt;

    assign gt = $signed(a) > $signed(b);

    always_comb begin
        if (compute)    lane_out = {W{gt}};
        else if (clear) lane_out = '0;
        else            lane_out = prior;
    end
endmodule

// File: rtl/sqcmp_unit.sv
module sqcmp_unit
    import sqcmp_pkg::*;
#(
    parameter int LANE_W = ELEM_W,
    parameter int LANES  = ELEM_CNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              in_mode,
    input  logic [LANE_W*LANES-1:0] src_a,
    input  logic [LANE_W*LANES-1:0] src_b,
    input  logic [LANE_W*LANES-1:0] dest_prev,
    output logic                    out_valid,
    output logic [LANE_W*LANES-1:0] out_result,
    output logic                    out_illegal
);
    localparam int VEC_W  = LANE_W * LANES;
    localparam int HALF_W = VEC_W / 2;

    logic             dec_illegal;
    logic [LANES-1:0] dec_compute;
    logic [LANES-1:0] dec_clear;
    logic [VEC_W-1:0] next_vec;
    logic [VEC_W-1:0] res_q;
    stat_t            stat_q;

    sqcmp_decode #(.LANES(LANES)) i_decode (
        .mode    (in_mode),
        .illegal (dec_illegal),
        .compute (dec_compute),
        .clear   (dec_clear)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            sqcmp_lane #(.W(LANE_W)) i_lane (
                .a        (src_a[i*LANE_W +: LANE_W]),
                .b        (src_b[i*LANE_W +: LANE_W]),
                .compute  (dec_compute[i]),
                .clear    (dec_clear[i]),
                .prior    (dest_prev[i*LANE_W +: LANE_W]),
                .lane_out (next_vec[i*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q.vld <= in_valid;
            if (in_valid) begin
                res_q          <= next_vec;
                stat_q.illegal <= dec_illegal;
            end
        end
    end

    assign out_valid   = stat_q.vld;
    assign out_result  = res_q;
    assign out_illegal = stat_q.illegal;

    // R8: strobe follows the input one cycle later
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: result and flag hold while idle
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
    // R6: flag tracks the illegal code
    p_flag_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_illegal == ($past(in_mode) == 2'b11)));
    // R7: illegal leaves the destination as it was
    p_illegal_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=> (out_result == $past(dest_prev)));
    // R4: narrow keep carries the upper half
    p_keep_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=>
            (out_result[VEC_W-1:HALF_W] == $past(dest_prev[VEC_W-1:HALF_W])));
    // R5: narrow clear zeroes the upper half
    p_zero_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01) |=> (out_result[VEC_W-1:HALF_W] == '0));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_chk
            if (g < LANES / 2) begin : g_low
                // R2: computed lower lanes are clean masks
                p_lane_mask_r2: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && !out_illegal) |->
                        ((out_result[g*LANE_W +: LANE_W] == '0) ||
                         (out_result[g*LANE_W +: LANE_W] == '1)));
            end
        end
    endgenerate
endmodule

// File: tb/test_sqcmp_unit.sv
module test_sqcmp_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = 2'b00;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [255:0] dest_prev = '0;
    logic         out_valid;
    logic [255:0] out_result;
    logic         out_illegal;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct packed {
        logic [255:0] res;
        logic         ill;
        logic [1:0]   mode;
        int           due;
    } exp_t;

    exp_t sb[$];

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    sqcmp_unit i_sqcmp_unit (
        .clk, .rst, .in_valid, .in_mode, .src_a, .src_b, .dest_prev,
        .out_valid, .out_result, .out_illegal
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [255:0] model(input logic [1:0] m, input logic [255:0] a,
                                           input logic [255:0] b, input logic [255:0] d);
        logic [255:0] r;
        r = d;
        if (m != 2'b11) begin
            for (int i = 0; i < 4; i++) begin
                if (i < 2 || m == 2'b10)
                    r[i*64 +: 64] = ($signed(a[i*64 +: 64]) > $signed(b[i*64 +: 64])) ? '1 : '0;
                else if (m == 2'b01)
                    r[i*64 +: 64] = '0;
            end
        end
        return r;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [255:0] a,
                         input logic [255:0] b, input logic [255:0] d);
        exp_t e;
        @(posedge clk);
        #1;
        in_valid = 1'b1; in_mode = m; src_a = a; src_b = b; dest_prev = d;
        e.res = model(m, a, b, d);
        e.ill = (m == 2'b11);
        e.mode = m;
        e.due = cyc + 1;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_mode = 2'($urandom);
            src_a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            src_b = ~src_a;
            dest_prev = {8{$urandom}};
        end
    endtask

    // monitor: compares outputs with the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R8 unexpected valid", 256'(out_valid), 256'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.due == cyc, "R8 latency", 256'(cyc), 256'(e.due));
                    check(out_result == e.res, mode_tag(e.mode), out_result, e.res);
                    check(out_illegal == e.ill, "R6", 256'(out_illegal), 256'(e.ill));
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                check(0, "R8 missing valid", 256'(out_valid), 256'(1));
                void'(sb.pop_front());
            end
        end
    end

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [255:0] held;
        logic         held_ill;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(out_result == '0 && !out_valid && !out_illegal, "R10 reset",
              out_result, '0);
        rst = 1'b0;

        // R1 R2: boundary pairs in lanes 0..3, wide mode (R3)
        drive(2'b10, {64'd0, MAXP, MINN, 64'd5}, {NEG1, NEG1, MAXP, 64'd5}, '1);
        // R1: -1 > min true, small positives, narrow keep (R4)
        drive(2'b00, {rnd256()}, {rnd256()}, {MAXP, MINN, 128'd0} | {128'd0, NEG1, NEG1});
        drive(2'b00, {128'h0, NEG1, 64'd3}, {128'h0, MINN, 64'd4}, {NEG1, 64'h1234, 128'h0});
        // R5: narrow clear with upper sources that would compare true
        drive(2'b01, {MAXP, MAXP, MAXP, 64'd0}, {MINN, MINN, MINN, NEG1}, '1);
        // R6 R7: illegal code keeps destination
        drive(2'b11, '1, '0, rnd256());
        // R6: legal op right after clears flag
        drive(2'b10, {MINN, 64'd1, NEG1, MAXP}, {MAXP, 64'd0, 64'd0, MAXP}, '0);
        idle(2);
        for (int n = 0; n < 40; n++) begin
            drive(2'(n % 4), rnd256(), rnd256(), rnd256());
            if (n % 5 == 0) idle(1);
        end
        drive(2'b10, rnd256(), rnd256(), rnd256());
        idle(3);

        // R9: result and flag hold while idle
        held = out_result;
        held_ill = out_illegal;
        idle(4);
        @(negedge clk);
        check(out_result == held && out_illegal == held_ill && !out_valid, "R9 hold",
              out_result, held);

        // R10: reset after activity
        drive(2'b11, '0, '0, '1);
        idle(2);
        @(posedge clk);
        #1;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(out_result == '0 && !out_valid && !out_illegal, "R10 clear",
              out_result, '0);
        rst = 1'b0;
        idle(2);
        check(sb.size() == 0, "R8 drained", 256'(sb.size()), 256'(0));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule